// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point words in a four-stage pipeline. Stage one marks each operand as zero or nonzero. Stage two restores the hidden leading one of each mantissa and lines the operands up on the larger exponent. Stage three forms the magnitude sum or difference and fixes the result sign. Stage four normalizes the result, packs it and classifies it with a status code. One operand pair can enter on every enabled cycle, and a valid flag travels with each pair.

A single enable gates every stage register. While the enable is low the whole pipeline, including the output, is frozen. The block does no rounding: mantissa bits that shift out are dropped. Infinities, NaNs and denormal inputs are not handled. An operand whose exponent field is zero counts as zero.

Top module: `fpas_top`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is zero is treated as zero whatever its fraction bits (bits 22:0) hold.
- R2: When exactly one operand is zero, the result is the other operand unchanged with status 4'b0000. For a subtraction with a zero first operand, the result is the second operand with bit 31 inverted.
- R3: When both operands are zero, the result is 32'h00000000 with status 4'b0100.
- R4: The operand with the smaller exponent has its mantissa (hidden one included) shifted right by the exponent difference, and the larger exponent is used. Bits shifted out are lost, so a difference of 24 or more contributes nothing.
- R5: When the effective signs are equal, the mantissas are added and the result takes that common sign.
- R6: When the effective signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. Equal magnitudes give 32'h00000000 with status 4'b0100.
- R7: With sub_sel=1 the sign of opb is inverted before the operation. With sub_sel=0 the operands are added.
- R8: When the mantissa sum carries out above the hidden bit, the exponent goes up by one and the mantissa is shifted right by one, dropping its lowest bit.
- R9: When there is no carry, the mantissa is shifted left until its top bit is 1, and the exponent goes down by one for each shift.
- R10: If the result exponent reaches 255, the result is {sign, 8'hFF, 23'h0} with status 4'b0001 (overflow).
- R11: If normalization brings the exponent to zero or below, the result is {sign, 31'h0} with status 4'b0010 (underflow).
- R12: The result of a pair taken with in_valid=1 appears on result and status with out_valid=1 after exactly four enabled clock edges, in issue order, one pair per cycle. Status is 4'b0000 for a normal result and never has more than one bit set.
- R13: While en=0 no stage advances: out_valid, result and status hold, and a pair already in flight completes only after further enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advances all pipeline stages when high |
| in_valid | input | 1 | Operand pair on opa/opb is valid |
| sub_sel | input | 1 | 0: opa + opb, 1: opa - opb |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | result/status carry a new result |
| result | output | 32 | Packed sum or difference |
| status | output | 4 | 0000 normal, 0001 overflow, 0010 underflow, 0100 zero |

## Verification
A stage that keeps a wrong zero flag, a mis-aligned mantissa or a wrong sign shows up as a wrong result word exactly four enabled edges after the pair is issued. Many such faults show only in the low fraction bits, so the directed vectors include one-unit-in-the-last-place cases and truncation cases as well as the large-value cases. Faults in the valid chain or in the enable gating show up one cycle early or late on out_valid, or as output changes while the enable is low. Faults in the overflow and underflow classes show up as a status code that does not match the packed exponent.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int SUM_W  = MANT_W + 1;
    localparam int LZ_W   = $clog2(MANT_W + 1);
    localparam int XEXP_W = EXP_W + 2;
    localparam int SGN_B  = WORD_W - 1;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    typedef logic [3:0] stat_t;
    localparam stat_t ST_NORMAL = 4'b0000;
    localparam stat_t ST_OVF    = 4'b0001;
    localparam stat_t ST_UNF    = 4'b0010;
    localparam stat_t ST_ZERO   = 4'b0100;

    // stage 1: zero detection
    typedef struct packed {
        logic              vld;
        logic              sub;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic              za;
        logic              zb;
    } zs_t;

    // stage 2: hidden bit and alignment
    typedef struct packed {
        logic              vld;
        logic              sa;
        logic              sb;
        logic [EXP_W-1:0]  ex;
        logic [MANT_W-1:0] ma;
        logic [MANT_W-1:0] mb;
        logic              za;
        logic              zb;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
    } al_t;

    // stage 3: magnitude arithmetic
    typedef struct packed {
        logic              vld;
        logic              byp;
        logic [WORD_W-1:0] byp_w;
        logic              sgn;
        logic [EXP_W-1:0]  ex;
        logic [SUM_W-1:0]  m;
    } ar_t;

    // stage 4: packed output
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
        stat_t             st;
    } nm_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [MANT_W-1:0] m);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (m[i]) seen = 1'b1;
            else if (!seen) n = n + LZ_W'(1);
        end
        return n;
    endfunction
endpackage

// File: rtl/fpas_st_zero.sv
module fpas_st_zero
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic              sub_sel,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output zs_t               zs_o
);
    zs_t zs_d, zs_q;

    always_comb begin
        zs_d     = zs_q;
        zs_d.vld = in_valid;
        if (in_valid) begin
            zs_d.sub = sub_sel;
            zs_d.a   = opa;
            zs_d.b   = opb;
            zs_d.za  = (opa[SGN_B-1 -: EXP_W] == '0);
            zs_d.zb  = (opb[SGN_B-1 -: EXP_W] == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  zs_q <= '0;
        else if (en) zs_q <= zs_d;
    end

    assign zs_o = zs_q;
endmodule

// File: rtl/fpas_st_align.sv
module fpas_st_align
    import fpas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  zs_t  zs_i,
    output al_t  al_o
);
    al_t al_d, al_q;

    always_comb begin
        logic [EXP_W-1:0]  ea, eb;
        logic [MANT_W-1:0] ma, mb;
        logic              sb_eff;
        ea     = zs_i.a[SGN_B-1 -: EXP_W];
        eb     = zs_i.b[SGN_B-1 -: EXP_W];
        ma     = {~zs_i.za, zs_i.a[FRAC_W-1:0]};
        mb     = {~zs_i.zb, zs_i.b[FRAC_W-1:0]};
        sb_eff = zs_i.b[SGN_B] ^ zs_i.sub;

        al_d     = al_q;
        al_d.vld = zs_i.vld;
        if (zs_i.vld) begin
            al_d.sa = zs_i.a[SGN_B];
            al_d.sb = sb_eff;
            al_d.za = zs_i.za;
            al_d.zb = zs_i.zb;
            al_d.a  = zs_i.a;
            al_d.b  = {sb_eff, zs_i.b[SGN_B-1:0]};
            if (ea >= eb) begin
                al_d.ex = ea;
                al_d.ma = ma;
                al_d.mb = mb >> (ea - eb);
            end else begin
                al_d.ex = eb;
                al_d.ma = ma >> (eb - ea);
                al_d.mb = mb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  al_q <= '0;
        else if (en) al_q <= al_d;
    end

    assign al_o = al_q;
endmodule

// File: rtl/fpas_st_arith.sv
module fpas_st_arith
    import fpas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  al_t  al_i,
    output ar_t  ar_o
);
    ar_t ar_d, ar_q;

    always_comb begin
        ar_d     = ar_q;
        ar_d.vld = al_i.vld;
        if (al_i.vld) begin
            ar_d.byp = al_i.za | al_i.zb;
            if (al_i.za && al_i.zb) ar_d.byp_w = '0;
            else if (al_i.za)       ar_d.byp_w = al_i.b;
            else                    ar_d.byp_w = al_i.a;
            ar_d.ex = al_i.ex;
            if (al_i.sa == al_i.sb) begin
                ar_d.m   = {1'b0, al_i.ma} + {1'b0, al_i.mb};
                ar_d.sgn = al_i.sa;
            end else if (al_i.ma >= al_i.mb) begin
                ar_d.m   = {1'b0, al_i.ma - al_i.mb};
                ar_d.sgn = al_i.sa;
            end else begin
                ar_d.m   = {1'b0, al_i.mb - al_i.ma};
                ar_d.sgn = al_i.sb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ar_q <= '0;
        else if (en) ar_q <= ar_d;
    end

    assign ar_o = ar_q;
endmodule

// File: rtl/fpas_st_norm.sv
module fpas_st_norm
    import fpas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  ar_t  ar_i,
    output nm_t  nm_o
);
    nm_t nm_d, nm_q;

    always_comb begin
        logic [XEXP_W-1:0] xe;
        logic [FRAC_W-1:0] fr;
        logic [LZ_W-1:0]   lz;
        xe = '0;
        fr = '0;
        lz = '0;

        nm_d     = nm_q;
        nm_d.vld = ar_i.vld;
        if (ar_i.vld) begin
            if (ar_i.byp) begin
                nm_d.res = ar_i.byp_w;
                nm_d.st  = (ar_i.byp_w[SGN_B-1:0] == '0) ? ST_ZERO : ST_NORMAL;
            end else if (ar_i.m == '0) begin
                nm_d.res = '0;
                nm_d.st  = ST_ZERO;
            end else begin
                if (ar_i.m[SUM_W-1]) begin
                    // carry out: becomes new hidden bit
                    xe = {2'b00, ar_i.ex} + XEXP_W'(1);
                    fr = FRAC_W'(ar_i.m >> 1);
                end else begin
                    lz = lead_zeros(ar_i.m[MANT_W-1:0]);
                    xe = {2'b00, ar_i.ex} - XEXP_W'(lz);
                    fr = FRAC_W'(ar_i.m[MANT_W-1:0] << lz);
                end
                if (xe[XEXP_W-1] || xe == '0) begin
                    nm_d.res = {ar_i.sgn, {(WORD_W-1){1'b0}}};
                    nm_d.st  = ST_UNF;
                end else if (xe >= {2'b00, EXP_MAX}) begin
                    nm_d.res = {ar_i.sgn, EXP_MAX, {FRAC_W{1'b0}}};
                    nm_d.st  = ST_OVF;
                end else begin
                    nm_d.res = {ar_i.sgn, xe[EXP_W-1:0], fr};
                    nm_d.st  = ST_NORMAL;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  nm_q <= '0;
        else if (en) nm_q <= nm_d;
    end

    assign nm_o = nm_q;
endmodule

// File: rtl/fpas_top.sv
module fpas_top
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic              sub_sel,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [3:0]        status
);
    zs_t zs;
    al_t al;
    ar_t ar;
    nm_t nm;

    fpas_st_zero u_zero (
        .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
        .sub_sel(sub_sel), .opa(opa), .opb(opb), .zs_o(zs)
    );

    fpas_st_align u_align (
        .clk(clk), .rst_n(rst_n), .en(en), .zs_i(zs), .al_o(al)
    );

    fpas_st_arith u_arith (
        .clk(clk), .rst_n(rst_n), .en(en), .al_i(al), .ar_o(ar)
    );

    fpas_st_norm u_norm (
        .clk(clk), .rst_n(rst_n), .en(en), .ar_i(ar), .nm_o(nm)
    );

    assign out_valid = nm.vld;
    assign result    = nm.res;
    assign status    = nm.st;
endmodule

// File: rtl/fpas_chk.sv
module fpas_chk
    import fpas_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic [3:0]        status
);
    // R12: one status code at a time
    a_r12_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

    // R12: four enabled edges from issue to output
    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_valid) ##1 en ##1 en ##1 en |=> out_valid);

    // R13: frozen outputs while disabled
    a_r13_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result) && $stable(status) && $stable(out_valid));

    // R3 / R6: zero status goes with an all-zero word
    a_r3_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_ZERO |-> result == '0);

    // R10: overflow word pattern
    a_r10_ovf_word: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_OVF |-> result[SGN_B-1 -: EXP_W] == EXP_MAX && result[FRAC_W-1:0] == '0);

    // R11: underflow word pattern
    a_r11_unf_word: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_UNF |-> result[SGN_B-1:0] == '0);
endmodule

bind fpas_top fpas_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .out_valid(out_valid), .result(result), .status(status)
);

// File: tb/sim_fpas_top.sv
module sim_fpas_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        in_valid = 1'b0;
    logic        sub_sel = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  status;

    int checks = 0;
    int errors = 0;

    fpas_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .sub_sel(sub_sel),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .status(status)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic s);
        opa = a; opb = b; sub_sel = s; in_valid = 1'b1;
    endtask

    // one pair, checked for exact latency, value and status
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic s, input logic [31:0] er, input logic [3:0] es);
        @(negedge clk); drive(a, b, s);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({tag, " R12 not early"}, {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check({tag, " R12 out_valid"}, {31'b0, out_valid}, 32'd1);
        check({tag, " result"}, result, er);
        check({tag, " status"}, {28'b0, status}, {28'b0, es});
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R12 reset result", result, 32'h0);
        check("R12 reset status", {28'b0, status}, 32'd0);
    endtask

    task automatic t_add_basic;
        run_op("R4 R5 align add", 32'h412570A4, 32'h401851EC, 1'b0, 32'h414B851F, 4'b0000);
        run_op("R7 sub of negative", 32'h413547AE, 32'hC037AE14, 1'b1, 32'h41633333, 4'b0000);
    endtask

    task automatic t_zero_cases;
        run_op("R1 R2 zero a", 32'h00123456, 32'h3FC00000, 1'b0, 32'h3FC00000, 4'b0000);
        run_op("R2 zero b", 32'hC0490FDB, 32'h00000000, 1'b0, 32'hC0490FDB, 4'b0000);
        run_op("R2 R7 zero a sub", 32'h00000000, 32'h40490FDB, 1'b1, 32'hC0490FDB, 4'b0000);
        run_op("R3 both zero", 32'h80000000, 32'h00000000, 1'b0, 32'h00000000, 4'b0100);
        run_op("R6 equal magnitudes", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'b0100);
    endtask

    task automatic t_signs;
        run_op("R6 a larger", 32'h3F800000, 32'hBF000000, 1'b0, 32'h3F000000, 4'b0000);
        run_op("R6 R7 b larger", 32'h3F000000, 32'h3F800000, 1'b1, 32'hBF000000, 4'b0000);
        run_op("R5 negative sum", 32'hBF800000, 32'hBF800000, 1'b0, 32'hC0000000, 4'b0000);
    endtask

    task automatic t_shift_edges;
        run_op("R4 diff 24 lost", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 4'b0000);
        run_op("R4 diff 23 kept", 32'h3F800000, 32'h34000000, 1'b0, 32'h3F800001, 4'b0000);
        run_op("R8 carry", 32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'b0000);
        run_op("R8 carry truncates", 32'h3F800001, 32'h3F800000, 1'b0, 32'h40000000, 4'b0000);
        run_op("R9 long left shift", 32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h34000000, 4'b0000);
    endtask

    task automatic t_range;
        run_op("R10 overflow pos", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'b0001);
        run_op("R10 overflow neg", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 4'b0001);
        run_op("R11 underflow pos", 32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 4'b0010);
        run_op("R11 underflow neg", 32'h80C00000, 32'h00800000, 1'b0, 32'h80000000, 4'b0010);
    endtask

    task automatic t_stream;
        @(negedge clk); drive(32'h3F800000, 32'h3F800000, 1'b0);
        @(negedge clk); drive(32'h3F800000, 32'hBF000000, 1'b0);
        @(negedge clk); drive(32'h3F000000, 32'h3F800000, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R12 stream 0 valid", {31'b0, out_valid}, 32'd1);
        check("R12 stream 0", result, 32'h40000000);
        @(negedge clk);
        check("R12 stream 1 valid", {31'b0, out_valid}, 32'd1);
        check("R12 stream 1", result, 32'h3F000000);
        @(negedge clk);
        check("R12 stream 2 valid", {31'b0, out_valid}, 32'd1);
        check("R12 stream 2", result, 32'hBF000000);
        @(negedge clk);
        check("R12 stream end", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_stall;
        logic [31:0] held;
        held = result;
        @(negedge clk); drive(32'h412570A4, 32'h401851EC, 1'b0);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); en = 1'b0;
        repeat (4) @(negedge clk);
        check("R13 stalled valid", {31'b0, out_valid}, 32'd0);
        check("R13 stalled result", result, held);
        en = 1'b1;
        @(negedge clk);
        check("R13 one edge short", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R13 resumed valid", {31'b0, out_valid}, 32'd1);
        check("R13 resumed result", result, 32'h414B851F);
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add_basic();
        t_zero_cases();
        t_signs();
        t_shift_edges();
        t_range();
        t_stream();
        t_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule